// File: doc/BRIEF.md
# Low-Power State Controller

This block governs the two sleep states of a small 8-bit microcontroller. Software raises a one-cycle request to enter either a light sleep, where only the CPU clock stops, or a deep sleep, where the oscillator itself is switched off. The block drives the clock enables and the oscillator enable. It decides when each sleep ends. It also drives the overrides that hold the external bus strobes and the address/data ports at defined levels while asleep.

The light sleep ends on any enabled pending interrupt or on the reset pin. The deep sleep ends only on the reset pin or on an external interrupt pin that is both enabled and set to level mode. That pin exit has two steps. Pulling the pin low turns the oscillator back on. The CPU clock returns only after the pin is high again and the oscillator reports itself stable. The reset pin produces an internal reset only after it has stayed high for two full machine cycles with the oscillator running. If light sleep is left through the reset pin, the CPU clock runs again at once, so internal RAM writes are blocked until the internal reset takes over.

Top module: `lowpower_ctl`

## Requirements
- R1: After the block's synchronous reset, the CPU clock, peripheral clock and oscillator enables are 1, and every override, `int_reset` and `ram_wr_block` are 0.
- R2: A one-cycle `idle_req` in the running state sets `cpu_clk_en` to 0 from the next cycle on, with `periph_clk_en` and `osc_en` left at 1. Both strobe overrides become active with a held level of 1.
- R3: A one-cycle `pdown_req` in the running state sets `cpu_clk_en`, `periph_clk_en` and `osc_en` to 0 from the next cycle on. Both strobe overrides become active with a held level of 0. If both requests arrive in the same cycle, deep sleep is entered.
- R4: In light sleep, `irq_pending` sampled high returns the block to the running state on the next cycle.
- R5: In deep sleep, `irq_pending` has no effect. An external pin also has no effect while its `ext_en` bit is 0 or its `ext_level` bit is 0 (edge mode). The pins are active-low.
- R6: In deep sleep, an external pin at 0 whose `ext_en` and `ext_level` bits are both 1 sets `osc_en` to 1 on the next cycle while both clock enables stay 0. The clocks return one cycle after every such pin is high again, provided `osc_stable` is 1.
- R7: While waking from deep sleep, `cpu_clk_en` stays 0 for as long as `osc_stable` is 0, even when the wake pin has already returned high.
- R8: `int_reset` rises once `reset_pin` has been sampled high on `2*MC_CLKS` consecutive qualified cycles. A cycle is qualified when the oscillator is enabled and stable. `int_reset` falls on the cycle after `reset_pin` is sampled low. While `int_reset` is high, the block is in the running state and ignores sleep requests.
- R9: In deep sleep, a high `reset_pin` turns the oscillator on. The reset pin takes priority over a wake pin in the same cycle. If the reset pin drops before `int_reset` rises, deep sleep resumes with the oscillator off.
- R10: When light sleep is left through `reset_pin`, from the next cycle `cpu_clk_en` is 1 and `ram_wr_block` is 1. Both hold until the cycle after `int_reset` rises. The reset pin takes priority over `irq_pending` in the same cycle.
- R11: With `ext_code` at 1, `p0_float` is 1 in light and deep sleep, and `p2_addr` is 1 in light sleep only. With `ext_code` at 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| idle_req | input | 1 | One-cycle software request for light sleep |
| pdown_req | input | 1 | One-cycle software request for deep sleep |
| irq_pending | input | 1 | Any enabled interrupt pending |
| ext_pin_n | input | NUM_EXT | External interrupt pins, active low, already synchronised |
| ext_en | input | NUM_EXT | Per-pin interrupt enable |
| ext_level | input | NUM_EXT | Per-pin level mode (1) or edge mode (0) |
| reset_pin | input | 1 | Reset pin, active high |
| osc_stable | input | 1 | Oscillator has settled |
| ext_code | input | 1 | Code is fetched from external memory |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| int_reset | output | 1 | Internal reset |
| ram_wr_block | output | 1 | Blocks internal RAM writes |
| ale_hold_en | output | 1 | Address-latch strobe override active |
| ale_hold_val | output | 1 | Level held on the address-latch strobe |
| psen_hold_en | output | 1 | Program-read strobe override active |
| psen_hold_val | output | 1 | Level held on the program-read strobe |
| p0_float | output | 1 | Multiplexed address/data port released to high impedance |
| p2_addr | output | 1 | Upper port keeps presenting the address byte |

## Verification
Two exit causes can land in the same cycle. In light sleep, a pending interrupt and the reset pin can rise together. In deep sleep, an enabled level-mode pin and the reset pin can go active together. The bench drives each pair on one clock edge and expects the reset path to win. In light sleep that means the CPU clock running with RAM writes blocked. In deep sleep it means the oscillator on, no later return to running, and then an internal reset. The same per-clock reference model also covers the case where both sleep requests arrive at once and deep sleep must win.

// File: rtl/lp_pkg.sv
// Shared types of the low-power controller.
package lp_pkg;
    typedef enum logic [2:0] {
        LP_RUN      = 3'd0,
        LP_IDLE     = 3'd1,
        LP_IDLE_RST = 3'd2,
        LP_PD       = 3'd3,
        LP_PD_WAKE  = 3'd4,
        LP_PD_RST   = 3'd5
    } lp_state_e;
endpackage

// File: rtl/lp_rst_qual.sv
// Reset-pin qualifier: asserts the internal reset once the pin has been high
// for RST_CYC qualified cycles (oscillator enabled and stable).
// Assumes reset_pin is already synchronous to clk.
module lp_rst_qual #(
    parameter int RST_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reset_pin,
    input  logic osc_ok,
    output logic int_rst
);
    localparam int CW = $clog2(RST_CYC + 1);

    logic [CW-1:0] cnt_q, cnt_n;

    // Next count: clear on a low pin, saturating increment on a qualified cycle.
    always_comb begin
        if (!reset_pin)
            cnt_n = '0;
        else if (osc_ok && (cnt_q != CW'(RST_CYC)))
            cnt_n = cnt_q + CW'(1);
        else
            cnt_n = cnt_q;
    end

    // Count register and registered reset output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            int_rst <= 1'b0;
        end else begin
            cnt_q   <= cnt_n;
            int_rst <= reset_pin && (cnt_n == CW'(RST_CYC));
        end
    end
endmodule

// File: rtl/lp_wake_det.sv
// Wake detector: flags any external pin that is low, enabled and level mode.
// Assumes the pins are already synchronised and active low.
module lp_wake_det #(
    parameter int NUM_EXT = 2
) (
    input  logic [NUM_EXT-1:0] ext_pin_n,
    input  logic [NUM_EXT-1:0] ext_en,
    input  logic [NUM_EXT-1:0] ext_level,
    output logic               wake
);
    logic [NUM_EXT-1:0] hit;

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_pin
        // Per-pin qualification.
        assign hit[i] = ext_en[i] && ext_level[i] && !ext_pin_n[i];
    end

    assign wake = |hit;
endmodule

// File: rtl/lp_state_fsm.sv
// Sleep state machine: sequences run, light sleep, deep sleep and their exits.
// Internal reset overrides everything; deep sleep wins over light sleep.
module lp_state_fsm
    import lp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle_req,
    input  logic      pdown_req,
    input  logic      irq_pending,
    input  logic      wake,
    input  logic      reset_pin,
    input  logic      osc_stable,
    input  logic      int_rst,
    output lp_state_e state
);
    lp_state_e st_n;

    // Next-state selection.
    always_comb begin
        st_n = state;
        if (int_rst) begin
            st_n = LP_RUN;
        end else begin
            unique case (state)
                LP_RUN: begin
                    if (pdown_req)     st_n = LP_PD;
                    else if (idle_req) st_n = LP_IDLE;
                end
                LP_IDLE: begin
                    if (reset_pin)        st_n = LP_IDLE_RST;
                    else if (irq_pending) st_n = LP_RUN;
                end
                LP_IDLE_RST: begin
                    if (!reset_pin) st_n = LP_RUN;
                end
                LP_PD: begin
                    if (reset_pin) st_n = LP_PD_RST;
                    else if (wake) st_n = LP_PD_WAKE;
                end
                LP_PD_WAKE: begin
                    if (!wake && osc_stable) st_n = LP_RUN;
                end
                LP_PD_RST: begin
                    if (!reset_pin) st_n = LP_PD;
                end
                default: st_n = LP_RUN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LP_RUN;
        else        state <= st_n;
    end
endmodule

// File: rtl/lp_pin_ovr.sv
// Output decode: clock enables and bus-pin overrides per state and code source.
module lp_pin_ovr
    import lp_pkg::*;
(
    input  lp_state_e state,
    input  logic      ext_code,
    output logic      cpu_clk_en,
    output logic      periph_clk_en,
    output logic      osc_en,
    output logic      ram_wr_block,
    output logic      ale_hold_en,
    output logic      ale_hold_val,
    output logic      psen_hold_en,
    output logic      psen_hold_val,
    output logic      p0_float,
    output logic      p2_addr
);
    logic in_idle, in_pd;

    // State class decode.
    always_comb begin
        in_idle = (state == LP_IDLE);
        in_pd   = (state == LP_PD) || (state == LP_PD_WAKE) || (state == LP_PD_RST);
    end

    // Clock and oscillator enables.
    always_comb begin
        cpu_clk_en    = (state == LP_RUN) || (state == LP_IDLE_RST);
        periph_clk_en = !in_pd;
        osc_en        = (state != LP_PD);
        ram_wr_block  = (state == LP_IDLE_RST);
    end

    // Strobe and port overrides.
    always_comb begin
        ale_hold_en   = in_idle || in_pd;
        ale_hold_val  = in_idle;
        psen_hold_en  = in_idle || in_pd;
        psen_hold_val = in_idle;
        p0_float      = ext_code && (in_idle || in_pd);
        p2_addr       = ext_code && in_idle;
    end
endmodule

// File: rtl/lowpower_ctl.sv
// Low-power state controller top: ties the reset qualifier, wake detector,
// state machine and output decode together. MC_CLKS is clocks per machine cycle.
module lowpower_ctl
    import lp_pkg::*;
#(
    parameter int MC_CLKS = 12,
    parameter int NUM_EXT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idle_req,
    input  logic               pdown_req,
    input  logic               irq_pending,
    input  logic [NUM_EXT-1:0] ext_pin_n,
    input  logic [NUM_EXT-1:0] ext_en,
    input  logic [NUM_EXT-1:0] ext_level,
    input  logic               reset_pin,
    input  logic               osc_stable,
    input  logic               ext_code,
    output logic               cpu_clk_en,
    output logic               periph_clk_en,
    output logic               osc_en,
    output logic               int_reset,
    output logic               ram_wr_block,
    output logic               ale_hold_en,
    output logic               ale_hold_val,
    output logic               psen_hold_en,
    output logic               psen_hold_val,
    output logic               p0_float,
    output logic               p2_addr
);
    localparam int RST_CYC = 2 * MC_CLKS;

    lp_state_e state;
    logic      wake;

    lp_rst_qual #(.RST_CYC(RST_CYC)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_pin (reset_pin),
        .osc_ok    (osc_en && osc_stable),
        .int_rst   (int_reset)
    );

    lp_wake_det #(.NUM_EXT(NUM_EXT)) u_wake (
        .ext_pin_n (ext_pin_n),
        .ext_en    (ext_en),
        .ext_level (ext_level),
        .wake      (wake)
    );

    lp_state_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_req    (idle_req),
        .pdown_req   (pdown_req),
        .irq_pending (irq_pending),
        .wake        (wake),
        .reset_pin   (reset_pin),
        .osc_stable  (osc_stable),
        .int_rst     (int_reset),
        .state       (state)
    );

    lp_pin_ovr u_ovr (
        .state         (state),
        .ext_code      (ext_code),
        .cpu_clk_en    (cpu_clk_en),
        .periph_clk_en (periph_clk_en),
        .osc_en        (osc_en),
        .ram_wr_block  (ram_wr_block),
        .ale_hold_en   (ale_hold_en),
        .ale_hold_val  (ale_hold_val),
        .psen_hold_en  (psen_hold_en),
        .psen_hold_val (psen_hold_val),
        .p0_float      (p0_float),
        .p2_addr       (p2_addr)
    );
endmodule

// File: rtl/lowpower_ctl_chk.sv
// Property checker for the low-power controller, bound to every instance.
module lowpower_ctl_chk #(
    parameter int NUM_EXT = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pdown_req,
    input logic [NUM_EXT-1:0] ext_pin_n,
    input logic [NUM_EXT-1:0] ext_en,
    input logic [NUM_EXT-1:0] ext_level,
    input logic               reset_pin,
    input logic               osc_stable,
    input logic               cpu_clk_en,
    input logic               periph_clk_en,
    input logic               osc_en,
    input logic               int_reset,
    input logic               ram_wr_block,
    input logic               ale_hold_en,
    input logic               ale_hold_val,
    input logic               p2_addr
);
    logic pin_wake;
    assign pin_wake = |(ext_en & ext_level & ~ext_pin_n);

    p_osc_off_clocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!cpu_clk_en && !periph_clk_en));

    p_pd_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && !ram_wr_block && !int_reset && pdown_req) |=> !osc_en);

    p_idle_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_hold_en && ale_hold_val) |-> (periph_clk_en && !cpu_clk_en));

    p_osc_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && (pin_wake || reset_pin)) |=> osc_en);

    p_stable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_clk_en) && !$past(periph_clk_en) && !$past(int_reset)) |-> $past(osc_stable));

    p_rst_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_pin |=> !int_reset);

    p_block_runs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_block |-> cpu_clk_en);

    p_addr_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        p2_addr |-> (!cpu_clk_en && periph_clk_en));
endmodule

bind lowpower_ctl lowpower_ctl_chk #(.NUM_EXT(NUM_EXT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pdown_req     (pdown_req),
    .ext_pin_n     (ext_pin_n),
    .ext_en        (ext_en),
    .ext_level     (ext_level),
    .reset_pin     (reset_pin),
    .osc_stable    (osc_stable),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .osc_en        (osc_en),
    .int_reset     (int_reset),
    .ram_wr_block  (ram_wr_block),
    .ale_hold_en   (ale_hold_en),
    .ale_hold_val  (ale_hold_val),
    .p2_addr       (p2_addr)
);

// File: tb/lowpower_ctl_bench.sv
// Bench: scripted stimulus, behavioural per-clock reference model, compare every clock.
module lowpower_ctl_bench;
    localparam int MC  = 12;
    localparam int NE  = 2;
    localparam int RC  = 2 * MC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle_req = 0, pdown_req = 0, irq_pending = 0;
    logic [NE-1:0] ext_pin_n = '1, ext_en = '1, ext_level = '1;
    logic reset_pin = 0, osc_stable = 1, ext_code = 0;
    logic cpu_clk_en, periph_clk_en, osc_en, int_reset, ram_wr_block;
    logic ale_hold_en, ale_hold_val, psen_hold_en, psen_hold_val, p0_float, p2_addr;

    int    vectors = 0, fails = 0, cycles = 0;
    string cur_tag = "R1";
    bit    started = 0;

    // model: 0 run, 1 light sleep, 2 light sleep left by reset, 3 deep, 4 deep waking, 5 deep reset
    int m_mode = 0, m_cnt = 0;
    bit m_irst = 0;

    always #10 clk = ~clk;

    lowpower_ctl #(.MC_CLKS(MC), .NUM_EXT(NE)) u_lowpower_ctl (.*);

    // Reference model update.
    always @(posedge clk) begin
        int  nm, nc;
        bit  osc_on, wk;
        started <= 1;
        if (!rst_n) begin
            m_mode <= 0; m_cnt <= 0; m_irst <= 0;
        end else begin
            osc_on = (m_mode != 3);
            wk = |(ext_en & ext_level & ~ext_pin_n);
            nc = !reset_pin ? 0 : ((osc_on && osc_stable && m_cnt < RC) ? m_cnt + 1 : m_cnt);
            nm = m_mode;
            if (m_irst) nm = 0;
            else case (m_mode)
                0: if (pdown_req) nm = 3; else if (idle_req) nm = 1;
                1: if (reset_pin) nm = 2; else if (irq_pending) nm = 0;
                2: if (!reset_pin) nm = 0;
                3: if (reset_pin) nm = 5; else if (wk) nm = 4;
                4: if (!wk && osc_stable) nm = 0;
                5: if (!reset_pin) nm = 3;
                default: nm = 0;
            endcase
            m_cnt <= nc; m_mode <= nm; m_irst <= reset_pin && (nc == RC);
        end
    end

    task automatic cmp(string nm, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", cur_tag, nm, act, exp, cycles);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        bit sl, dp;
        cycles++;
        if (started) begin
            sl = (m_mode == 1);
            dp = (m_mode >= 3);
            cmp("cpu_clk_en",    cpu_clk_en,    m_mode == 0 || m_mode == 2);
            cmp("periph_clk_en", periph_clk_en, !dp);
            cmp("osc_en",        osc_en,        m_mode != 3);
            cmp("int_reset",     int_reset,     m_irst);
            cmp("ram_wr_block",  ram_wr_block,  m_mode == 2);
            cmp("ale_hold_en",   ale_hold_en,   sl || dp);
            cmp("ale_hold_val",  ale_hold_val,  sl);
            cmp("psen_hold_en",  psen_hold_en,  sl || dp);
            cmp("psen_hold_val", psen_hold_val, sl);
            cmp("p0_float",      p0_float,      ext_code && (sl || dp));
            cmp("p2_addr",       p2_addr,       ext_code && sl);
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        cur_tag = "R1"; tick(3); rst_n = 1; tick(2);
        // light sleep entry and interrupt exit
        cur_tag = "R2"; idle_req = 1; tick(1); idle_req = 0; tick(4);
        cur_tag = "R4"; irq_pending = 1; tick(1); irq_pending = 0; tick(2);
        // external code: port overrides in light sleep
        cur_tag = "R11"; ext_code = 1; idle_req = 1; tick(1); idle_req = 0; tick(3);
        irq_pending = 1; tick(1); irq_pending = 0; tick(2);
        // deep sleep and ignored wake sources
        cur_tag = "R3"; pdown_req = 1; tick(1); pdown_req = 0; tick(3);
        cur_tag = "R5"; irq_pending = 1; tick(2); irq_pending = 0;
        ext_level = 2'b10; ext_pin_n = 2'b10; tick(3);
        ext_pin_n = 2'b11; ext_level = 2'b11; ext_en = 2'b01; ext_pin_n = 2'b01; tick(3);
        ext_pin_n = 2'b11; ext_en = 2'b11; tick(1);
        // two-step pin exit with slow oscillator
        cur_tag = "R6"; osc_stable = 0; ext_pin_n = 2'b10; tick(4);
        cur_tag = "R7"; ext_pin_n = 2'b11; tick(4); osc_stable = 1; tick(3); ext_code = 0;
        // both requests together, wake on the other pin
        cur_tag = "R3"; idle_req = 1; pdown_req = 1; tick(1); idle_req = 0; pdown_req = 0; tick(3);
        cur_tag = "R6"; ext_pin_n = 2'b01; tick(2); ext_pin_n = 2'b11; tick(3);
        // reset pin from running, request ignored during internal reset
        cur_tag = "R8"; reset_pin = 1; tick(RC + 4); idle_req = 1; tick(1); idle_req = 0; tick(2);
        reset_pin = 0; tick(3);
        reset_pin = 1; tick(10); reset_pin = 0; tick(3);
        // light sleep left by reset, interrupt in the same cycle
        cur_tag = "R10"; idle_req = 1; tick(1); idle_req = 0; tick(3);
        reset_pin = 1; irq_pending = 1; tick(1); irq_pending = 0; tick(RC + 5);
        reset_pin = 0; tick(3);
        // deep sleep with reset pin: short then long
        cur_tag = "R9"; pdown_req = 1; tick(1); pdown_req = 0; tick(3);
        reset_pin = 1; tick(5); reset_pin = 0; tick(3);
        reset_pin = 1; tick(RC + 6); reset_pin = 0; tick(3);
        // deep sleep: wake pin and reset pin together
        pdown_req = 1; tick(1); pdown_req = 0; tick(3);
        ext_pin_n = 2'b10; reset_pin = 1; tick(RC + 6);
        ext_pin_n = 2'b11; reset_pin = 0; tick(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule